// File: doc/BRIEF.md
# Receive Buffer Overrun Capture Unit

This block guards a receive buffer of word entries that a transfer sequencer fills and a bus master drains. It keeps one "holds unread data" bit per entry. A sequencer write sets that bit, and a bus-master read of the entry clears it. When the sequencer writes an entry whose bit is still set, the write still goes through. The block then marks that write as an overrun, raises a sticky overrun flag and latches where the collision happened.

The latched location is a word-aligned byte offset in the buffer's address window. It starts at 0x200, and entry `i` maps to `0x200 + 4*i`. Only the first collision is kept. Reading the capture register hands the address to software, clears the flag and arms the capture for the next event.

Any entry can instead be put in suspend mode. In that mode the sequencer is held off through its ready signal until the bus master has read the old contents, so that entry can never overrun. An interrupt output follows the flag, gated by an enable input.

Top module: `rxovr_guard`

## Requirements
- R1: A sequencer write that is accepted (`wr_req` high with `wr_rdy` high) to an entry that still holds unread data drives `wr_ovr` high in that same cycle, and the new word is stored.
- R2: An accepted write marks its entry as holding unread data, and a bus-master read marks it empty. A read and a write to the same entry in the same cycle do not count as an overrun, and that read returns the old word.
- R3: `cap_rdata[9:0]` holds the captured address `0x200 + 4*index`, ranging from 0x200 to 0x3FC. `cap_rdata[31:10]` is always zero.
- R4: After reset every entry is empty, `ovr_flag` and `irq` are 0, and `cap_rdata` reads 0x200.
- R5: While `ovr_flag` is set, later overruns leave the captured address unchanged.
- R6: A cycle with `cap_rd` high and no new overrun clears `ovr_flag` and returns the address field to 0x200 from the next cycle on. `cap_rdata` in the read cycle shows the value held before the clear.
- R7: If an overrun and `cap_rd` fall in the same cycle, the flag is set in the next cycle and the captured address is that of the new overrun.
- R8: For an entry configured for suspend (`susp_cfg_val` = 1), `wr_rdy` is low while the entry holds unread data. A held write stores nothing and flags no overrun. `wr_rdy` returns high once the entry has been read.
- R9: `irq` is high exactly when `ovr_flag` is high and `irq_en` is high.
- R10: Read data for `rd_en` appears on `rd_data` one cycle later, with `rd_vld` high in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_req | input | 1 | Sequencer write request |
| wr_idx | input | 7 | Entry index for the write |
| wr_data | input | 16 | Word to store |
| wr_rdy | output | 1 | Write can be accepted this cycle |
| wr_ovr | output | 1 | Accepted write overwrites unread data |
| susp_cfg_we | input | 1 | Update the suspend mode of one entry |
| susp_cfg_idx | input | 7 | Entry whose suspend mode is updated |
| susp_cfg_val | input | 1 | New suspend mode (1 = wait until read) |
| rd_en | input | 1 | Bus-master read of an entry |
| rd_idx | input | 7 | Entry index for the read |
| rd_data | output | 16 | Read word, one cycle after `rd_en` |
| rd_vld | output | 1 | `rd_data` is valid |
| cap_rd | input | 1 | Read of the capture register (clears it) |
| cap_rdata | output | 32 | Capture register contents |
| ovr_flag | output | 1 | Overrun flag; address valid while set |
| irq_en | input | 1 | Interrupt enable |
| irq | output | 1 | Overrun interrupt |

## Verification
Two of the block's functions can land in the same cycle: the capture-register read that clears the flag, and a fresh overrun that must set it again. The bench first sets the flag from one entry. It then issues `cap_rd` in the very cycle the sequencer overwrites a second, full entry. The flag must still be high afterwards and must hold the second entry's address. A second collision case writes and reads the same entry together. That case is judged by `wr_ovr` staying low and by the scoreboard receiving the old word.

// File: rtl/rxovr_pkg.sv
package rxovr_pkg;
    localparam int DEPTH    = 128;
    localparam int IDX_W    = $clog2(DEPTH);
    localparam int DATA_W   = 16;
    localparam int CAP_W    = 32;
    localparam int OFFS_W   = 10;
    localparam logic [OFFS_W-1:0] OFFS_BASE = 10'h200;

    typedef struct packed {
        logic              req;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] data;
    } wr_cmd_t;

    typedef struct packed {
        logic              en;
        logic [IDX_W-1:0]  idx;
    } rd_cmd_t;

    typedef struct packed {
        logic              flag;
        logic [OFFS_W-1:0] offs;
    } cap_state_t;

    function automatic logic [OFFS_W-1:0] idx_to_offs(input logic [IDX_W-1:0] idx);
        logic [OFFS_W-1:0] w;
        w = '0;
        w[IDX_W+1:2] = idx;
        return OFFS_BASE + w;
    endfunction
endpackage

// File: rtl/rxovr_occupancy.sv
module rxovr_occupancy
    import rxovr_pkg::*;
#(
    parameter int N   = DEPTH,
    parameter int IW  = IDX_W,
    parameter int DW  = DATA_W
) (
    input  logic             clk,
    input  logic             rst,
    input  wr_cmd_t          wr,
    input  rd_cmd_t          rd,
    input  logic             cfg_we,
    input  logic [IW-1:0]    cfg_idx,
    input  logic             cfg_val,
    output logic             wr_rdy,
    output logic             wr_fire,
    output logic             ovr_hit
);
    logic [N-1:0] full_q;
    logic [N-1:0] susp_q;
    logic         same_entry;

    assign same_entry = rd.en && (rd.idx == wr.idx);
    assign wr_rdy     = !(susp_q[wr.idx] && full_q[wr.idx]);
    assign wr_fire    = wr.req && wr_rdy;
    assign ovr_hit    = wr_fire && full_q[wr.idx] && !same_entry;

    for (genvar g = 0; g < N; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                full_q[g] <= 1'b0;
                susp_q[g] <= 1'b0;
            end else begin
                if (wr_fire && wr.idx == IW'(g))
                    full_q[g] <= 1'b1;
                else if (rd.en && rd.idx == IW'(g))
                    full_q[g] <= 1'b0;
                if (cfg_we && cfg_idx == IW'(g))
                    susp_q[g] <= cfg_val;
            end
        end
    end

    AST_SUSP_NO_OVR: assert property (@(posedge clk) disable iff (rst)
        (wr.req && susp_q[wr.idx] && full_q[wr.idx]) |-> !ovr_hit); // R8
    AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (rst)
        wr_fire |=> full_q[$past(wr.idx)]); // R2
endmodule

// File: rtl/rxovr_store.sv
module rxovr_store
    import rxovr_pkg::*;
#(
    parameter int N  = DEPTH,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  wr_cmd_t       wr,
    input  logic          wr_fire,
    input  rd_cmd_t       rd,
    output logic [DW-1:0] rd_data,
    output logic          rd_vld
);
    logic [DW-1:0] mem [N];

    always_ff @(posedge clk) begin
        if (wr_fire)
            mem[wr.idx] <= wr.data;
        if (rd.en)
            rd_data <= mem[rd.idx];
    end

    always_ff @(posedge clk) begin
        if (rst) rd_vld <= 1'b0;
        else     rd_vld <= rd.en;
    end

    AST_RD_LATENCY: assert property (@(posedge clk) disable iff (rst)
        rd.en |=> rd_vld); // R10
endmodule

// File: rtl/rxovr_capture.sv
module rxovr_capture
    import rxovr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              hit,
    input  logic [IDX_W-1:0]  hit_idx,
    input  logic              cap_rd,
    output cap_state_t        st
);
    cap_state_t nx;

    always_comb begin
        nx = st;
        if (cap_rd) begin
            nx.flag = 1'b0;
            nx.offs = OFFS_BASE;
        end
        if (hit && !nx.flag) begin
            nx.flag = 1'b1;
            nx.offs = idx_to_offs(hit_idx);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st.flag <= 1'b0;
            st.offs <= OFFS_BASE;
        end else begin
            st <= nx;
        end
    end

    AST_FIRST_KEPT: assert property (@(posedge clk) disable iff (rst)
        (st.flag && !cap_rd) |=> (st.flag && $stable(st.offs))); // R5
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (cap_rd && !hit) |=> (!st.flag && st.offs == OFFS_BASE)); // R6
    AST_REARM: assert property (@(posedge clk) disable iff (rst)
        (cap_rd && hit) |=> (st.flag && st.offs == idx_to_offs($past(hit_idx)))); // R7
    AST_OFFS_RANGE: assert property (@(posedge clk) disable iff (rst)
        (st.offs[1:0] == 2'b00 && st.offs >= OFFS_BASE)); // R3
endmodule

// File: rtl/rxovr_guard.sv
module rxovr_guard
    import rxovr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_req,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic [DATA_W-1:0]    wr_data,
    output logic                 wr_rdy,
    output logic                 wr_ovr,
    input  logic                 susp_cfg_we,
    input  logic [IDX_W-1:0]     susp_cfg_idx,
    input  logic                 susp_cfg_val,
    input  logic                 rd_en,
    input  logic [IDX_W-1:0]     rd_idx,
    output logic [DATA_W-1:0]    rd_data,
    output logic                 rd_vld,
    input  logic                 cap_rd,
    output logic [CAP_W-1:0]     cap_rdata,
    output logic                 ovr_flag,
    input  logic                 irq_en,
    output logic                 irq
);
    wr_cmd_t    wr;
    rd_cmd_t    rd;
    cap_state_t cap;
    logic       fire;
    logic       hit;

    assign wr = '{req: wr_req, idx: wr_idx, data: wr_data};
    assign rd = '{en: rd_en, idx: rd_idx};

    rxovr_occupancy u_occ (
        .clk     (clk),
        .rst     (rst),
        .wr      (wr),
        .rd      (rd),
        .cfg_we  (susp_cfg_we),
        .cfg_idx (susp_cfg_idx),
        .cfg_val (susp_cfg_val),
        .wr_rdy  (wr_rdy),
        .wr_fire (fire),
        .ovr_hit (hit)
    );

    rxovr_store u_store (
        .clk     (clk),
        .rst     (rst),
        .wr      (wr),
        .wr_fire (fire),
        .rd      (rd),
        .rd_data (rd_data),
        .rd_vld  (rd_vld)
    );

    rxovr_capture u_cap (
        .clk     (clk),
        .rst     (rst),
        .hit     (hit),
        .hit_idx (wr_idx),
        .cap_rd  (cap_rd),
        .st      (cap)
    );

    assign wr_ovr    = hit;
    assign ovr_flag  = cap.flag;
    assign cap_rdata = {{(CAP_W-OFFS_W){1'b0}}, cap.offs};
    assign irq       = cap.flag && irq_en;

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
        irq |-> (ovr_flag && irq_en)); // R9
    AST_HIT_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
        wr_ovr |=> ovr_flag); // R1
endmodule

// File: tb/rxovr_guard_bench.sv
module rxovr_guard_bench;
    import rxovr_pkg::*;

    logic clk = 1'b0;
    logic rst;
    logic wr_req = 0, susp_cfg_we = 0, susp_cfg_val = 0, rd_en = 0, cap_rd = 0, irq_en = 0;
    logic [IDX_W-1:0] wr_idx = '0, susp_cfg_idx = '0, rd_idx = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic wr_rdy, wr_ovr, rd_vld, ovr_flag, irq;
    logic [DATA_W-1:0] rd_data;
    logic [CAP_W-1:0] cap_rdata;

    int checks = 0, errors = 0;
    bit done = 0;
    logic [DATA_W-1:0] m_mem [DEPTH];
    logic [DEPTH-1:0]  m_full = '0;
    logic [DATA_W-1:0] exp_q [$];

    always #5 clk = ~clk;

    rxovr_guard u_rxovr_guard (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // monitor: pops expected read words as the design returns them (R10)
    always @(negedge clk) begin
        if (!rst && rd_vld) begin
            if (exp_q.size() == 0) check("R10 unexpected rd_vld", 1, 0);
            else check("R10 R1 read data", 32'(rd_data), 32'(exp_q.pop_front()));
        end
    end

    // one cycle of traffic; the write is expected to be accepted
    task automatic cyc(input bit w, input int wi, input logic [15:0] wd,
                       input bit r, input int ri, input bit cr, input string tag);
        bit exp_ovr;
        @(negedge clk);
        wr_req = w; wr_idx = IDX_W'(wi); wr_data = wd;
        rd_en = r; rd_idx = IDX_W'(ri); cap_rd = cr;
        exp_ovr = w && m_full[wi] && !(r && ri == wi);
        #1;
        if (w) check({tag, " wr_ovr"}, 32'(wr_ovr), 32'(exp_ovr));
        if (r) begin exp_q.push_back(m_mem[ri]); m_full[ri] = 1'b0; end
        if (w) begin m_mem[wi] = wd; m_full[wi] = 1'b1; end
        @(posedge clk); #1;
        wr_req = 0; rd_en = 0; cap_rd = 0;
    endtask

    initial begin
        #100000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        check("R4 reset cap", cap_rdata, 32'h200);
        check("R4 reset flag", 32'(ovr_flag), 0);
        check("R4 reset irq", 32'(irq), 0);

        cyc(1, 5, 16'hAAAA, 0, 0, 0, "R4 first write empty");
        cyc(1, 5, 16'hBBBB, 0, 0, 0, "R1 overwrite");
        check("R1 flag set", 32'(ovr_flag), 1);
        check("R3 capture idx5", cap_rdata, 32'h214);
        check("R9 irq masked", 32'(irq), 0);
        irq_en = 1; #1;
        check("R9 irq enabled", 32'(irq), 1);

        cyc(1, 9, 16'h1111, 0, 0, 0, "R2 write 9");
        cyc(1, 9, 16'h2222, 0, 0, 0, "R5 second overrun");
        check("R5 first address kept", cap_rdata, 32'h214);

        cyc(0, 0, 0, 1, 5, 0, "R1 read back 5");
        @(negedge clk);
        check("R6 value before clear", cap_rdata, 32'h214);
        cyc(0, 0, 0, 0, 0, 1, "R6 capture read");
        check("R6 flag cleared", 32'(ovr_flag), 0);
        check("R6 addr reset", cap_rdata, 32'h200);
        check("R9 irq follows flag", 32'(irq), 0);

        cyc(0, 0, 0, 1, 9, 0, "R2 drain 9");
        cyc(1, 9, 16'h3333, 0, 0, 0, "R2 write after read");
        check("R2 no flag", 32'(ovr_flag), 0);
        cyc(1, 9, 16'h4444, 1, 9, 0, "R2 same-cycle rd/wr");
        check("R2 no flag same cycle", 32'(ovr_flag), 0);

        cyc(1, 0, 16'h0A0A, 0, 0, 0, "R7 fill 0");
        cyc(1, 0, 16'h0B0B, 0, 0, 0, "R7 overrun 0");
        check("R3 capture idx0", cap_rdata, 32'h200);
        check("R7 flag before", 32'(ovr_flag), 1);
        cyc(1, 127, 16'h7777, 0, 0, 0, "R7 fill 127");
        check("R5 idx0 kept", cap_rdata, 32'h200);
        cyc(1, 127, 16'h7878, 0, 0, 1, "R7 overrun with cap read");
        check("R7 flag rearmed", 32'(ovr_flag), 1);
        check("R7 R3 capture idx127", cap_rdata, 32'h3FC);
        check("R3 upper bits zero", 32'(cap_rdata[31:10]), 0);
        cyc(0, 0, 0, 1, 127, 1, "R1 read 127 and clear");

        // suspend on entry 20
        @(negedge clk);
        susp_cfg_we = 1; susp_cfg_idx = 7'd20; susp_cfg_val = 1;
        @(posedge clk); #1 susp_cfg_we = 0;
        cyc(1, 20, 16'h5050, 0, 0, 0, "R8 fill 20");
        @(negedge clk);
        wr_req = 1; wr_idx = 7'd20; wr_data = 16'hDEAD; #1;
        check("R8 ready low", 32'(wr_rdy), 0);
        check("R8 no ovr when held", 32'(wr_ovr), 0);
        @(posedge clk); #1 wr_req = 0;
        check("R8 flag stays clear", 32'(ovr_flag), 0);
        cyc(0, 0, 0, 1, 20, 0, "R8 drain 20");
        @(negedge clk);
        wr_idx = 7'd20; #1;
        check("R8 ready after read", 32'(wr_rdy), 1);
        repeat (3) @(negedge clk);
        check("R10 queue drained", 32'(exp_q.size()), 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule